// File: doc/BRIEF.md
# USB Clock Source Select and Gate

This block derives the USB device clock strobe from one of two PLL outputs. Both PLL outputs arrive as single-cycle enable pulses on one common fast clock, each with its own lock flag. A configuration bit picks the source, and a divider field sets how many source pulses make up one USB strobe. The strobe is produced only while software has switched the device clock on and the chosen PLL is locked.

Software uses a small register port. Writing a one to the turn-on register enables the clock, and writing a one to the turn-off register disables it. A configuration register holds the source select and the divider. A status register shows whether the clock is actually running. Register access is plain control traffic. There is no back-pressure: a write takes effect at the clock edge where `wr_en` is high, and reads are combinational from `rd_addr`.

Top module: `usbck_gate`

## Requirements
- R1: After reset the enable is off, the source is PLL A (select 0), the divider is 0, `usb_strobe` is low and every register reads 0.
- R2: A write to address 0 with bit 0 set turns the device clock enable on from the next cycle.
- R3: A write to address 1 with bit 0 set turns the device clock enable off from the next cycle.
- R4: A write of 0 in bit 0 to address 0 or address 1 leaves the enable unchanged.
- R5: Address 2 holds the configuration. Bit 0 selects the source (0 = PLL A, 1 = PLL B) and bits [7:4] hold the divider N. It reads back as written, with all other bits reading 0.
- R6: While gated on, `usb_strobe` is high for one cycle, one cycle after every (N+1)-th pulse of the selected source. N = 0 passes every pulse through. Pulses of the unselected source have no effect.
- R7: While the selected PLL's lock flag is low, or the enable is off, no strobe is produced and the pulse count is cleared. Counting restarts from zero once the clock is gated on again.
- R8: Address 3 bit 0 reads 1 exactly when the enable is on and the selected PLL is locked. Addresses 0 and 1 read the raw enable in bit 0.
- R9: Any write to address 2 clears the pulse count and suppresses a strobe in that cycle. The first strobe after the write follows N+1 further selected pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_a_pulse | input | 1 | PLL A output, one-cycle pulse per period |
| pll_b_pulse | input | 1 | PLL B output, one-cycle pulse per period |
| pll_a_lock | input | 1 | PLL A lock flag |
| pll_b_lock | input | 1 | PLL B lock flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| usb_strobe | output | 1 | Divided USB clock strobe |

## Verification
A wrong pulse count shows up as a strobe that arrives early or late relative to the selected source pulses. A per-cycle comparison of `usb_strobe` therefore exposes it within at most N+1 selected pulses. A stuck or wrong enable, select or divider register is visible at once through `rd_data`, and by the next selected pulse it also shows as a missing or extra strobe. Lock gating errors appear in the first cycle where the lock flag is dropped while pulses continue.

// File: rtl/usbck_pkg.sv
package usbck_pkg;
  typedef enum logic [1:0] {
    RA_ON   = 2'd0,
    RA_OFF  = 2'd1,
    RA_CFG  = 2'd2,
    RA_STAT = 2'd3
  } usbck_addr_e;

  localparam int CFG_SEL_BIT = 0;
  localparam int CFG_DIV_LSB = 4;
endpackage

// File: rtl/usbck_regs.sv
module usbck_regs
  import usbck_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            en_o,
  output logic            sel_o,
  output logic [DIVW-1:0] div_o,
  output logic            restart_o
);
  logic            en_q;
  logic            sel_q;
  logic [DIVW-1:0] div_q;
  logic            hit_on, hit_off, hit_cfg;

  assign hit_on  = wr_en && (wr_addr == RA_ON)  && wr_data[0];
  assign hit_off = wr_en && (wr_addr == RA_OFF) && wr_data[0];
  assign hit_cfg = wr_en && (wr_addr == RA_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      div_q <= '0;
    end else begin
      if (hit_off)     en_q <= 1'b0;
      else if (hit_on) en_q <= 1'b1;
      if (hit_cfg) begin
        sel_q <= wr_data[CFG_SEL_BIT];
        div_q <= wr_data[CFG_DIV_LSB +: DIVW];
      end
    end
  end

  assign en_o      = en_q;
  assign sel_o     = sel_q;
  assign div_o     = div_q;
  assign restart_o = hit_cfg;

  AST_ON_WRITE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_ON && wr_data[0]) |=> en_q) else $error("on write"); // R2
  AST_OFF_WRITE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_OFF && wr_data[0]) |=> !en_q) else $error("off write"); // R3
  AST_ZERO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == RA_ON || wr_addr == RA_OFF) && !wr_data[0]) |=> $stable(en_q))
    else $error("zero write"); // R4
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == RA_CFG) |=> ($stable(sel_q) && $stable(div_q)))
    else $error("cfg drift"); // R5
endmodule

// File: rtl/usbck_src_mux.sv
module usbck_src_mux #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0]         pulse_vec,
  input  logic [NSRC-1:0]         lock_vec,
  input  logic [$clog2(NSRC)-1:0] sel,
  output logic                    pulse_o,
  output logic                    lock_o
);
  logic [NSRC-1:0] pick;

  for (genvar i = 0; i < NSRC; i++) begin : g_pick
    assign pick[i] = (sel == i);
  end

  assign pulse_o = |(pulse_vec & pick);
  assign lock_o  = |(lock_vec & pick);
endmodule

// File: rtl/usbck_div.sv
module usbck_div #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pulse,
  input  logic            gate,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            strobe_o
);
  logic [DIVW-1:0] cnt_q;
  logic            stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else if (restart || !gate) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else if (pulse) begin
      if (cnt_q >= div) begin
        cnt_q <= '0;
        stb_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        stb_q <= 1'b0;
      end
    end else begin
      stb_q <= 1'b0;
    end
  end

  assign strobe_o = stb_q;

  AST_STROBE_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(pulse && gate && !restart)) else $error("stray strobe"); // R6
  AST_DIV0_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && gate && !restart && div == '0) |=> stb_q) else $error("div0"); // R6
  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !gate) |=> (cnt_q == '0 && !stb_q)) else $error("count clear"); // R9
endmodule

// File: rtl/usbck_gate.sv
module usbck_gate
  import usbck_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pll_a_pulse,
  input  logic          pll_b_pulse,
  input  logic          pll_a_lock,
  input  logic          pll_b_lock,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          usb_strobe
);
  localparam int NSRC = 2;

  logic            en, sel, restart, pulse_s, lock_s, active;
  logic [DIVW-1:0] div;

  usbck_regs #(.DW(DW), .DIVW(DIVW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_o(en), .sel_o(sel), .div_o(div), .restart_o(restart)
  );

  usbck_src_mux #(.NSRC(NSRC)) u_mux (
    .pulse_vec({pll_b_pulse, pll_a_pulse}),
    .lock_vec ({pll_b_lock, pll_a_lock}),
    .sel(sel), .pulse_o(pulse_s), .lock_o(lock_s)
  );

  assign active = en && lock_s;

  usbck_div #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .pulse(pulse_s), .gate(active),
    .restart(restart), .div(div), .strobe_o(usb_strobe)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      RA_ON, RA_OFF: rd_data[0] = en;
      RA_CFG: begin
        rd_data[CFG_SEL_BIT]          = sel;
        rd_data[CFG_DIV_LSB +: DIVW] = div;
      end
      RA_STAT: rd_data[0] = active;
      default: rd_data = '0;
    endcase
  end

  AST_NO_STROBE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    usb_strobe |-> $past(en && (sel ? pll_b_lock : pll_a_lock))) else $error("unlocked strobe"); // R7
  AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == RA_STAT) |-> (rd_data[0] == (en && (sel ? pll_b_lock : pll_a_lock))))
    else $error("status"); // R8
endmodule

// File: tb/sim_usbck_gate.sv
`timescale 1ns/1ps
module sim_usbck_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pa = 0, pb = 0, la = 0, lb = 0, we = 0;
  logic [1:0] wa = 0, ra = 0;
  logic [7:0] wd = 0;
  logic [7:0] rd_data;
  logic       usb_strobe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_en = 0, m_sel = 0;
  int m_div = 0, m_cnt = 0;

  always #10 clk = ~clk;

  usbck_gate u0 (
    .clk(clk), .rst_n(rst_n), .pll_a_pulse(pa), .pll_b_pulse(pb),
    .pll_a_lock(la), .pll_b_lock(lb), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_addr(ra), .rd_data(rd_data), .usb_strobe(usb_strobe)
  );

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    logic [7:0] v = 8'h00;
    case (a)
      2'd0, 2'd1: v[0] = m_en;
      2'd2: begin v[0] = m_sel; v[7:4] = m_div[3:0]; end
      default: v[0] = m_en && (m_sel ? lb : la);
    endcase
    return v;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle from a negedge, predict the strobe, check at the next negedge
  task automatic cyc(bit ipa, bit ipb, bit ila, bit ilb, bit iwe, logic [1:0] iwa,
                     logic [7:0] iwd, string req);
    bit exp_s, lsel, psel;
    pa = ipa; pb = ipb; la = ila; lb = ilb; we = iwe; wa = iwa; wd = iwd;
    lsel = m_sel ? ilb : ila;
    psel = m_sel ? ipb : ipa;
    exp_s = 0;
    if ((iwe && iwa == 2'd2) || !(m_en && lsel)) m_cnt = 0;
    else if (psel) begin
      if (m_cnt >= m_div) begin exp_s = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (iwe && iwa == 2'd1 && iwd[0]) m_en = 0;
    else if (iwe && iwa == 2'd0 && iwd[0]) m_en = 1;
    if (iwe && iwa == 2'd2) begin m_sel = iwd[0]; m_div = int'(iwd[7:4]); end
    @(posedge clk); @(negedge clk);
    we = 0; pa = 0; pb = 0;
    check(req, {7'd0, usb_strobe}, {7'd0, exp_s});
  endtask

  task automatic rdchk(logic [1:0] a, string req);
    ra = a; #1;
    check(req, rd_data, exp_rd(a));
  endtask

  task automatic pulses(int n, bit useb, bit ila, bit ilb, string req);
    for (int i = 0; i < n; i++) begin
      cyc(!useb, useb, ila, ilb, 0, 2'd0, 8'h00, req);
      cyc(0, 0, ila, ilb, 0, 2'd0, 8'h00, req);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rdchk(a[1:0], "R1");
    check("R1", {7'd0, usb_strobe}, 8'd0);
    // R2 enable on, A locked, div 0 passes pulses
    cyc(0, 0, 1, 0, 1, 2'd0, 8'h01, "R2");
    rdchk(2'd0, "R2"); rdchk(2'd3, "R8");
    pulses(4, 0, 1, 0, "R6");
    // R6 unselected source ignored
    pulses(3, 1, 1, 1, "R6");
    // R5 config: select B, divider 3
    cyc(0, 0, 1, 1, 1, 2'd2, 8'h31, "R5");
    rdchk(2'd2, "R5");
    pulses(9, 1, 1, 1, "R6");
    // R9 restart mid-count
    pulses(2, 1, 1, 1, "R9");
    cyc(0, 1, 1, 1, 1, 2'd2, 8'h31, "R9");
    pulses(5, 1, 1, 1, "R9");
    // R7 lock lost on B
    pulses(6, 1, 1, 0, "R7");
    rdchk(2'd3, "R8");
    pulses(5, 1, 1, 1, "R7");
    // R4 zero writes
    cyc(0, 0, 1, 1, 1, 2'd1, 8'hFE, "R4"); rdchk(2'd1, "R4");
    cyc(0, 0, 1, 1, 1, 2'd0, 8'hFE, "R4"); rdchk(2'd0, "R4");
    // R3 disable
    cyc(0, 0, 1, 1, 1, 2'd1, 8'h01, "R3"); rdchk(2'd0, "R3");
    pulses(4, 1, 1, 1, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit rwe;
      logic [1:0] rwa;
      rwe = ($urandom % 16) == 0;
      rwa = 2'($urandom % 3);
      cyc(($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 8) != 0,
          ($urandom % 8) != 0, rwe, rwa, 8'($urandom), "R6");
      if ((i % 50) == 0) rdchk(2'($urandom % 4), "R8");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule